// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block picks which of a set of DMA channels the shared transfer engine serves next. Every channel brings its own request line and receives its own one-cycle completion pulse. A per-channel enable bit decides whether the channel takes part at all. A per-channel priority bit places the channel's request in either the high level or the default level.

Any eligible high-level request wins over every default-level request. Inside one level the lowest-numbered channel wins. The winner keeps the grant until the engine strobes the end of its arbitration unit. In that same cycle the arbiter picks again, so the next grant appears one cycle after the strobe. If the engine marks the unit as the last one of the channel's transfer count, the channel that just lost the grant gets a done pulse.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset the grant vector is all zeros, the valid output is low, the channel number is 0 and no done bit is set.
- R2: An enabled, requesting channel whose priority bit is 1 is granted before any enabled, requesting channel whose priority bit is 0, whatever their channel numbers.
- R3: Among eligible requests at the same level, the channel with the lowest number is granted.
- R4: A request from a channel whose enable bit is 0 is never granted, whatever its priority bit.
- R5: While a grant is active and `unit_done_i` is low, the grant and channel number stay unchanged, even if requests, enables or priority bits change.
- R6: When `unit_done_i` is high during an active grant, the arbiter chooses again from the inputs of that cycle. The new grant, or all zeros, appears on the next cycle.
- R7: When `unit_done_i` and `last_unit_i` are both high during an active grant, the `chan_done_o` bit of the granted channel is 1 for exactly the following cycle. If `last_unit_i` is low, no done bit is set.
- R8: When no enabled channel requests, the arbiter is idle with an all-zero grant, valid low and channel number 0.
- R9: The grant vector has at most one bit set. The valid output equals the OR of the grant bits, and the channel number is the index of the set bit.
- R10: A `unit_done_i` strobe while no grant is active has no effect: no done bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_CH | Per-channel request lines |
| en_i | input | NUM_CH | Per-channel enable bits |
| hi_prio_i | input | NUM_CH | Per-channel priority bit (1 = high level) |
| unit_done_i | input | 1 | Engine strobe: current arbitration unit finished |
| last_unit_i | input | 1 | With the strobe: channel's transfer count is exhausted |
| grant_o | output | NUM_CH | One-hot grant |
| grant_id_o | output | $clog2(NUM_CH) | Number of the granted channel |
| grant_valid_o | output | 1 | A grant is active |
| chan_done_o | output | NUM_CH | One-cycle per-channel completion pulse |

## Verification
The bench places a low-numbered default-level channel against a high-numbered high-level channel. A design that ranked by channel number alone would grant the wrong one. It raises a high-priority request and drops the current requester during an active unit. A design that pre-empts would move the grant before the strobe. It checks back-to-back units, where the done pulse of the old channel and the new grant appear in the same cycle, and a strobe while idle, which must produce no done pulse. It also tries disabled channels that request at the high level and the top channel number, which catch masking mistakes and an off-by-one search.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    // Priority levels in descending order of precedence.
    typedef enum logic [0:0] {
        LVL_HIGH = 1'b0,
        LVL_DFLT = 1'b1
    } arb_level_e;

    localparam int unsigned NUM_LEVELS = 2;
endpackage

// File: rtl/dma_arb_ffs.sv
// Lowest-index find-first-set over a request vector.
module dma_arb_ffs #(
    parameter int unsigned WIDTH = 21,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [WIDTH-1:0] onehot_o
);
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o  = 1'b1;
                idx_o    = IDX_W'(i);
                onehot_o = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_arb_level_sel.sv
// Splits eligible requests into priority levels and picks the winner.
module dma_arb_level_sel
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 21,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] elig_i,
    input  logic [NUM_CH-1:0] hi_prio_i,
    output logic              found_o,
    output logic [CH_W-1:0]   idx_o,
    output logic [NUM_CH-1:0] onehot_o
);
    logic [NUM_LEVELS-1:0]             lvl_found;
    logic [NUM_LEVELS-1:0][CH_W-1:0]   lvl_idx;
    logic [NUM_LEVELS-1:0][NUM_CH-1:0] lvl_onehot;
    logic [NUM_LEVELS-1:0][NUM_CH-1:0] lvl_mask;

    assign lvl_mask[LVL_HIGH] = elig_i & hi_prio_i;
    assign lvl_mask[LVL_DFLT] = elig_i & ~hi_prio_i;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        dma_arb_ffs #(.WIDTH(NUM_CH)) ffs_i (
            .vec_i    (lvl_mask[g]),
            .found_o  (lvl_found[g]),
            .idx_o    (lvl_idx[g]),
            .onehot_o (lvl_onehot[g])
        );
    end

    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
            if (lvl_found[l]) begin
                found_o  = 1'b1;
                idx_o    = lvl_idx[l];
                onehot_o = lvl_onehot[l];
            end
        end
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
    parameter int unsigned NUM_CH = 21,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] hi_prio_i,
    input  logic              unit_done_i,
    input  logic              last_unit_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic [CH_W-1:0]   grant_id_o,
    output logic              grant_valid_o,
    output logic [NUM_CH-1:0] chan_done_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] grant;
        logic [CH_W-1:0]   id;
        logic              valid;
        logic [NUM_CH-1:0] done;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic              win_found;
    logic [CH_W-1:0]   win_idx;
    logic [NUM_CH-1:0] win_onehot;

    dma_arb_level_sel #(.NUM_CH(NUM_CH)) sel_i (
        .elig_i    (req_i & en_i),
        .hi_prio_i (hi_prio_i),
        .found_o   (win_found),
        .idx_o     (win_idx),
        .onehot_o  (win_onehot)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = '0;
        if (!st_q.valid || unit_done_i) begin
            if (st_q.valid && unit_done_i && last_unit_i) begin
                st_d.done = st_q.grant;
            end
            st_d.valid = win_found;
            st_d.grant = win_found ? win_onehot : '0;
            st_d.id    = win_found ? win_idx : '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o       = st_q.grant;
    assign grant_id_o    = st_q.id;
    assign grant_valid_o = st_q.valid;
    assign chan_done_o   = st_q.done;

    assert_grant_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

    assert_grant_id_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o |-> grant_o[grant_id_o]);

    assert_hold_until_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_valid_o && !unit_done_i) |=> ($stable(grant_o) && $stable(grant_id_o)));

    assert_done_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chan_done_o != '0) |-> ($past(unit_done_i && last_unit_i && grant_valid_o)
                                 && chan_done_o == $past(grant_o)));

    assert_idle_no_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grant_valid_o |=> (chan_done_o == '0));

    assert_grant_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(grant_valid_o) |-> ($past(en_i & req_i) & grant_o) != '0);
endmodule

// File: tb/dma_chan_arbiter_tb_top.sv
module dma_chan_arbiter_tb_top;
    localparam int unsigned NUM_CH = 21;
    localparam int unsigned CH_W = $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] req = '0;
    logic [NUM_CH-1:0] en = '0;
    logic [NUM_CH-1:0] hi = '0;
    logic              udone = 1'b0;
    logic              ulast = 1'b0;
    logic [NUM_CH-1:0] grant;
    logic [CH_W-1:0]   gid;
    logic              gvalid;
    logic [NUM_CH-1:0] cdone;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_chan_arbiter #(.NUM_CH(NUM_CH)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .req_i (req), .en_i (en),
        .hi_prio_i (hi), .unit_done_i (udone), .last_unit_i (ulast),
        .grant_o (grant), .grant_id_o (gid), .grant_valid_o (gvalid),
        .chan_done_o (cdone)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_grant(input string tag, input int ch);
        logic [NUM_CH-1:0] exp;
        exp = '0;
        if (ch >= 0) exp[ch] = 1'b1;
        chk(grant == exp, tag, grant, exp);
        chk(gvalid == (ch >= 0), tag, gvalid, ch >= 0);
        chk(gid == CH_W'((ch >= 0) ? ch : 0), tag, gid, (ch >= 0) ? ch : 0);
    endtask

    task automatic finish_unit(input bit last);
        udone = 1'b1;
        ulast = last;
        tick();
        udone = 1'b0;
        ulast = 1'b0;
    endtask

    task automatic t_reset();
        chk_grant("R1 reset grant", -1);
        chk(cdone == '0, "R1 reset done", cdone, 0);
    endtask

    task automatic t_idle_disabled();
        en = '0;
        req = 21'h1FFFFF;
        hi = 21'h1FFFFF;
        tick();
        chk_grant("R4/R8 all disabled idle", -1);
        req = '0;
        en = 21'h1FFFFF;
        hi = '0;
        tick();
        chk_grant("R8 no request idle", -1);
    endtask

    task automatic t_level();
        req = (21'(1) << 3) | (21'(1) << 17);
        hi = 21'(1) << 17;
        tick();
        chk_grant("R2 high level beats lower number", 17);
        req = '0;
        hi = '0;
        finish_unit(1'b0);
        chk_grant("R6 release to idle", -1);
        chk(cdone == '0, "R7 no done without last", cdone, 0);
    endtask

    task automatic t_lowest();
        req = (21'(1) << 5) | (21'(1) << 9) | (21'(1) << 20);
        hi = '0;
        tick();
        chk_grant("R3 lowest default channel", 5);
        hi = (21'(1) << 9) | (21'(1) << 20);
        finish_unit(1'b1);
        chk_grant("R3/R6 lowest high channel back to back", 9);
        chk(cdone == (21'(1) << 5), "R7 done pulse ch5", cdone, 21'(1) << 5);
        tick();
        chk(cdone == '0, "R7 done lasts one cycle", cdone, 0);
        req = '0;
        hi = '0;
        finish_unit(1'b0);
        chk_grant("R6 idle after unit", -1);
    endtask

    task automatic t_hold();
        req = 21'(1) << 10;
        tick();
        chk_grant("R3 single channel", 10);
        req = 21'(1) << 0;
        hi = 21'(1) << 0;
        tick();
        tick();
        chk_grant("R5 no pre-emption", 10);
        finish_unit(1'b1);
        chk_grant("R6 re-arbitrate after strobe", 0);
        chk(cdone == (21'(1) << 10), "R7 done pulse ch10", cdone, 21'(1) << 10);
        req = '0;
        hi = '0;
        finish_unit(1'b0);
        chk_grant("R6 idle", -1);
    endtask

    task automatic t_disabled();
        req = (21'(1) << 2) | (21'(1) << 4);
        hi = 21'(1) << 2;
        en = ~(21'(1) << 2);
        tick();
        chk_grant("R4 disabled high request ignored", 4);
        req = '0;
        hi = '0;
        en = 21'h1FFFFF;
        finish_unit(1'b0);
        req = 21'(1) << 20;
        tick();
        chk_grant("R9 top channel number", 20);
        req = '0;
        finish_unit(1'b0);
    endtask

    task automatic t_spurious();
        finish_unit(1'b1);
        chk(cdone == '0, "R10 strobe while idle no done", cdone, 0);
        chk_grant("R10 strobe while idle stays idle", -1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_idle_disabled();
        t_level();
        t_lowest();
        t_hold();
        t_disabled();
        t_spurious();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule